// File: doc/BRIEF.md
# Display Interrupt Status Aggregator

This block collects one-cycle event pulses from a display controller (frame completion on bit 0, other events on higher bits) into a sticky status register. A separate enable register masks the stored events, and one level-sensitive interrupt line stays high while any masked bit is pending. Software acknowledges an event by writing a one to its status bit.

A read-only summary register gives an interrupt handler a first-level view of two things. One is whether this controller's masked interrupt is active. The other is whether a second, unrelated source (for example a serial display link) shows any raw status. All access uses a simple 32-bit register bus with separate read and write strobes, and read data returns one cycle after the read strobe.

Top module: `disp_irq_agg`

## Requirements
- R1: `irq_o` is high exactly when the stored status AND the stored enable is nonzero. It reflects the register values that result from each clock edge: events, status clears and enable writes.
- R2: A write to offset 0x0 (status) clears each status bit whose write-data bit is one. Status bits written as zero keep their value.
- R3: A write to offset 0x4 (enable) stores write-data bits 15:0. Enable bits 31:16 always read as zero.
- R4: A high `evt_i[k]` sets status bit k at the next clock edge. Bit 0 is the frame-done event.
- R5: Offset 0x8 (summary) reads bit 0 as the masked controller interrupt and bit 1 as the OR of all `link_irq_i` bits. All other bits read as zero.
- R6: An active-low reset clears status and enable, which forces `irq_o` low.
- R7: When an event and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R8: A read strobe latches the addressed register into `rd_data_o` at the next edge, using the values before that edge. Status and enable return their stored values, and unmapped offsets return zero. `rd_data_o` holds its value between reads.
- R9: Writes to the summary offset or to unmapped offsets change neither status nor enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| evt_i | input | 16 | Event pulses, one per status bit |
| link_irq_i | input | 4 | Raw status of the second interrupt source |
| irq_o | output | 1 | Level interrupt output |

## Verification
Random sparse event vectors are mixed with random clear masks and random 32-bit enable words. This separates a correct masked OR from one that ignores the enable, and it shows whether zero bits in a clear mask wrongly drop events. Directed cases follow:
- a lone frame-done pulse;
- an event colliding with a clear of the same bit;
- enable writes with the upper half set, which shows truncation;
- summary reads with the link source toggled independently of the controller;
- writes to the summary and unmapped offsets;
- a reset in mid-run with bits pending.

Every read is compared against a bench model that is sampled one edge earlier, so a read path that shows post-edge values stands out.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int unsigned OFS_STATUS  = 32'h0;
  localparam int unsigned OFS_ENABLE  = 32'h4;
  localparam int unsigned OFS_SUMMARY = 32'h8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_EN   = 2'd2,
    SEL_SUM  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/disp_irq_dec.sv
module disp_irq_dec
  import disp_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output reg_sel_e          sel_o,
  output logic              stat_we_o,
  output logic              en_we_o,
  output logic              sum_we_o
);
  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFS_STATUS):  sel_o = SEL_STAT;
      ADDR_W'(OFS_ENABLE):  sel_o = SEL_EN;
      ADDR_W'(OFS_SUMMARY): sel_o = SEL_SUM;
      default:              sel_o = SEL_NONE;
    endcase
  end

  assign stat_we_o = wr_en_i && (sel_o == SEL_STAT);
  assign en_we_o   = wr_en_i && (sel_o == SEL_EN);
  assign sum_we_o  = wr_en_i && (sel_o == SEL_SUM);
endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status #(
  parameter int unsigned IRQ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_W-1:0] evt_i,
  input  logic             clr_i,
  input  logic [IRQ_W-1:0] clr_mask_i,
  output logic [IRQ_W-1:0] status_o
);
  logic [IRQ_W-1:0] status_q;

  // one sticky cell per bit; event has priority over clear
  for (genvar gi = 0; gi < IRQ_W; gi++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       status_q[gi] <= 1'b0;
      else if (evt_i[gi])                status_q[gi] <= 1'b1;
      else if (clr_i && clr_mask_i[gi])  status_q[gi] <= 1'b0;
    end
  end

  assign status_o = status_q;

  // R4 R7
  evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  // R2
  clr_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((status_q & $past(clr_mask_i) & ~$past(evt_i)) == '0));

  // R2
  keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((status_q & ~$past(clr_mask_i)) == ($past(status_q | evt_i) & ~$past(clr_mask_i))));
endmodule

// File: rtl/disp_irq_enable.sv
module disp_irq_enable #(
  parameter int unsigned IRQ_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [IRQ_W-1:0]  enable_o
);
  logic [IRQ_W-1:0] enable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   enable_q <= '0;
    else if (we_i) enable_q <= wr_data_i[IRQ_W-1:0];
  end

  assign enable_o = enable_q;

  // R3
  en_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (enable_q == $past(wr_data_i[IRQ_W-1:0])));

  // R9
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(enable_q));
endmodule

// File: rtl/disp_irq_agg.sv
module disp_irq_agg
  import disp_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IRQ_W  = 16,
  parameter int unsigned LINK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [IRQ_W-1:0]  evt_i,
  input  logic [LINK_W-1:0] link_irq_i,
  output logic              irq_o
);
  localparam int unsigned SUM_PAD = DATA_W - 2;

  reg_sel_e         sel;
  logic             stat_we, en_we, sum_we;
  logic [IRQ_W-1:0] status, enable;
  logic [DATA_W-1:0] rd_mux, rd_q;
  logic             masked_any, link_any;

  disp_irq_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .sel_o     (sel),
    .stat_we_o (stat_we),
    .en_we_o   (en_we),
    .sum_we_o  (sum_we)
  );

  disp_irq_status #(.IRQ_W(IRQ_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .clr_i      (stat_we),
    .clr_mask_i (wr_data_i[IRQ_W-1:0]),
    .status_o   (status)
  );

  disp_irq_enable #(.IRQ_W(IRQ_W), .DATA_W(DATA_W)) u_enable (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (en_we),
    .wr_data_i (wr_data_i),
    .enable_o  (enable)
  );

  assign masked_any = |(status & enable);
  assign link_any   = |link_irq_i;
  assign irq_o      = masked_any;

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_mux = DATA_W'(status);
      SEL_EN:   rd_mux = DATA_W'(enable);
      SEL_SUM:  rd_mux = {{SUM_PAD{1'b0}}, link_any, masked_any};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign rd_data_o = rd_q;

  // R1
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((|evt_i) || en_we));

  // R1
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(stat_we || en_we));

  // R9
  sum_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_we && !(|evt_i)) |=> ($stable(status) && $stable(enable)));

  // R8
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: tb/disp_irq_agg_test.sv
module disp_irq_agg_test;
  localparam int unsigned AW = 8, DW = 32, IW = 16, LW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [IW-1:0] evt = '0;
  logic [LW-1:0] link = '0;
  logic          irq;

  int unsigned checks = 0, errors = 0;
  logic [IW-1:0] st_m = '0, en_m = '0;

  always #5 clk = ~clk;

  disp_irq_agg uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .evt_i(evt), .link_irq_i(link), .irq_o(irq)
  );

  function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a, logic [IW-1:0] s,
                                             logic [IW-1:0] e, logic [LW-1:0] l);
    case (a)
      8'h00:   return DW'(s);
      8'h04:   return DW'(e);
      8'h08:   return {30'd0, |l, |(s & e)};
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one bus cycle; irq checked every cycle, read data when rd is set
  task automatic step(string req, logic w, logic r, logic [AW-1:0] a,
                      logic [DW-1:0] d, logic [IW-1:0] ev, logic [LW-1:0] l);
    logic [DW-1:0] exp_rd;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wr_data = d; evt = ev; link = l;
    exp_rd = exp_read(a, st_m, en_m, l);
    @(posedge clk);
    #1;
    if (w && a == 8'h00) st_m = st_m & ~d[IW-1:0];
    st_m = st_m | ev;
    if (w && a == 8'h04) en_m = d[IW-1:0];
    check("R1 irq", DW'(irq), DW'(|(st_m & en_m)));
    if (r) check(req, rd_data, exp_rd);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    #1;
    // R6 reset state
    check("R6 irq in reset", DW'(irq), '0);
    check("R6 rd_data in reset", rd_data, '0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    step("R8 status after reset", 0, 1, 8'h00, 0, 0, 0);
    // R4 frame-done on bit 0, R1 irq once enabled
    step("R4", 0, 0, 8'h00, 0, 16'h0001, 0);
    step("R4 frame done", 0, 1, 8'h00, 0, 0, 0);
    step("R3", 1, 0, 8'h04, 32'hFFFF_0001, 0, 0);
    step("R3 upper bits zero", 0, 1, 8'h04, 0, 0, 0);
    step("R5 summary ctrl bit", 0, 1, 8'h08, 0, 0, 0);
    // R2 zero bits unchanged
    step("R4", 0, 0, 8'h00, 0, 16'h0110, 0);
    step("R2", 1, 0, 8'h00, 32'h0000_0100, 0, 0);
    step("R2 partial clear", 0, 1, 8'h00, 0, 0, 0);
    step("R2", 1, 0, 8'h00, 32'hFFFF_FFFF, 0, 0);
    step("R2 full clear", 0, 1, 8'h00, 0, 0, 0);
    // R7 collision
    step("R7", 1, 0, 8'h00, 32'h0000_0008, 16'h0008, 0);
    step("R7 event wins", 0, 1, 8'h00, 0, 0, 0);
    // R5 link source only
    step("R5 link bit", 0, 1, 8'h08, 0, 0, 4'b0100);
    step("R5 link clear", 0, 1, 8'h08, 0, 0, 4'b0000);
    // R9 ignored writes
    step("R9", 1, 0, 8'h08, 32'hFFFF_FFFF, 0, 0);
    step("R9", 1, 0, 8'h0C, 32'hFFFF_FFFF, 0, 0);
    step("R9 status kept", 0, 1, 8'h00, 0, 0, 0);
    step("R9 enable kept", 0, 1, 8'h04, 0, 0, 0);
    step("R8 unmapped reads zero", 0, 1, 8'h0C, 0, 0, 0);
    step("R8 idle", 0, 0, 8'h00, 0, 0, 0);
    check("R8 hold between reads", rd_data, '0);

    for (int i = 0; i < 400; i++) begin
      int unsigned op = $urandom % 8;
      logic [IW-1:0] ev = ($urandom % 4 == 0) ? IW'($urandom) : '0;
      logic [LW-1:0] l  = ($urandom % 3 == 0) ? LW'($urandom) : '0;
      logic [DW-1:0] d  = $urandom;
      case (op)
        0: step("R2 rand clear", 1, 0, 8'h00, d, ev, l);
        1: step("R3 rand enable", 1, 0, 8'h04, d, ev, l);
        2: step("R8 rand status read", 0, 1, 8'h00, 0, ev, l);
        3: step("R3 rand enable read", 0, 1, 8'h04, 0, ev, l);
        4: step("R5 rand summary read", 0, 1, 8'h08, 0, ev, l);
        5: step("R9 rand summary write", 1, 0, 8'h08, d, ev, l);
        6: step("R4 rand event", 0, 0, 8'h00, 0, ev, l);
        default: step("R8 rand unmapped read", 0, 1, 8'h10, 0, ev, l);
      endcase
    end

    // R6 reset in mid-run with bits pending
    step("R6", 1, 0, 8'h04, 32'h0000_FFFF, 16'hA5A5, 0);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    st_m = '0; en_m = '0;
    check("R6 irq drops", DW'(irq), '0);
    @(negedge clk);
    rst_ni = 1'b1;
    step("R6 status cleared", 0, 1, 8'h00, 0, 0, 0);
    step("R6 enable cleared", 0, 1, 8'h04, 0, 0, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule